// File: doc/BRIEF.md
# Lazy Condition Flag Evaluator

This block rebuilds a processor's condition flags some time after the instruction that produced them. Only a few facts about that instruction are kept: its operation class, its operand size (1, 2 or 4 bytes), the source, destination and result words, and the high word of the last multiply. From these the block derives negative (N), zero (Z), overflow (V) and carry (C) flags. One compare-style operation reports its carry in a separate R flag instead of C. The rebuild uses only the sign bits of the operands and the result word, not the full arithmetic.

The new flags are merged into a status word that the caller supplies. The bits selected by an update mask, plus the extend bit X, are cleared and then loaded from the new flags. In extended-arithmetic mode (X input high) a zero result cannot set Z; the Z bit can only keep its old value or be cleared. Evaluation is combinational. The merged status word is registered on a cycle in which the valid strobe is high.

Top module: `lazy_flag_eval`

## Requirements
- R1: For add-type operations (opKind 0 = add, 1 = subtract, 2 = compare), with sign bits s (source) and d (destination) taken at the operand size, a result whose sign bit is set produces N. It also produces V when s and d are both 0, or C when s and d are both 1. Flag positions in the status word are C=bit 0, V=bit 1, Z=bit 2, N=bit 3, X=bit 4 and R=bit 8.
- R2: For add-type operations with a result sign bit of 0, Z is set when the result masked to the operand size is zero. V is set when s and d are both 1, and C is set when either s or d is 1. opSize encodes the size in bytes: 1, 2 or 4.
- R3: Subtract (opKind 1) and compare (opKind 2) invert the source before the rules of R1 and R2 are applied, and invert the final C.
- R4: opKind 3 applies the add-type rules at 32 bits whatever opSize says, and places the carry-like result in R instead of C.
- R5: For opKind 4 (move, logic and shift) at size 4 or 2, only N (sign bit set at that size) or Z (zero at that size) is produced. At size 1 the add-type rules of R1 and R2 apply, with the source not inverted.
- R6: For opKind 5 (unsigned multiply), the 64-bit value {mofWord, resWord} sets Z when it is zero and N when its bit 63 is set. V is set when mofWord is nonzero.
- R7: For opKind 6 (signed multiply), Z or N comes from the signed 64-bit {mofWord, resWord}. V is set when mofWord is not the sign extension of resWord.
- R8: On a write, the effective mask is flagMask with the X bit added. Status bits under the effective mask take the new flag values, bits outside it keep statusIn, and X always ends up 0.
- R9: When xFlagIn is 1 and the new Z would be 1, Z is removed from the effective mask, so Z keeps the value it has in statusIn.
- R10: opKind 7 (flags live) performs no write, and a cycle with evalValid low performs no write. In both cases statusOut keeps its value.
- R11: For add-type paths with an opSize other than 1, 2 or 4, all new flags are 0, including the inverted C of subtract.
- R12: statusOut is 0 after reset. It shows the merged status in the cycle after the clock edge at which evalValid was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evalValid | input | 1 | Evaluate and write the status this cycle |
| opKind | input | 3 | Recorded operation class |
| opSize | input | 3 | Operand size in bytes (1, 2, 4) |
| srcWord | input | 32 | Recorded source operand |
| dstWord | input | 32 | Recorded destination operand |
| resWord | input | 32 | Recorded result |
| mofWord | input | 32 | High word of the multiply product |
| xFlagIn | input | 1 | Extended-arithmetic flag of the instruction |
| flagMask | input | 16 | Flags the operation may update |
| statusIn | input | 16 | Current status word |
| statusOut | output | 16 | Registered merged status word |

## Verification
Every result of this block appears at statusOut one clock edge after the edge that samples evalValid. The bench drives inputs on the falling edge, lets one rising edge capture them, and compares statusOut at the next falling edge. A table of vectors, each applied with a full mask and a zero status, covers the flag rules of each operation class. Directed sequences cover the mask merge and the retained Z. For writes that are blocked (flags-live and no valid), the bench checks after a further edge that statusOut still holds the value it had before.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_X = 4;
  localparam int BIT_R = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_MCP  = 3'd3,
    OP_MOVE = 3'd4,
    OP_MULU = 3'd5,
    OP_MULS = 3'd6,
    OP_LIVE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    WD_BYTE = 2'd0,
    WD_HALF = 2'd1,
    WD_WORD = 2'd2,
    WD_NONE = 2'd3
  } width_e;

  typedef struct packed {
    logic   doWrite;
    logic   useAdd;
    logic   useNz;
    logic   useMulU;
    logic   useMulS;
    logic   invSrc;
    logic   invCarry;
    logic   carryToR;
    width_e width;
  } ctrl_t;

endpackage

// File: rtl/lfe_ctrl.sv
module lfe_ctrl
  import lfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evalValid,
  input  op_e        opKind,
  input  logic [2:0] opSize,
  output ctrl_t      ctl
);

  width_e sizeWidth;

  always_comb begin
    case (opSize)
      3'd1:    sizeWidth = WD_BYTE;
      3'd2:    sizeWidth = WD_HALF;
      3'd4:    sizeWidth = WD_WORD;
      default: sizeWidth = WD_NONE;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.width   = sizeWidth;
    ctl.doWrite = evalValid && (opKind != OP_LIVE);
    case (opKind)
      OP_ADD: ctl.useAdd = 1'b1;
      OP_SUB, OP_CMP: begin
        ctl.useAdd   = 1'b1;
        ctl.invSrc   = 1'b1;
        ctl.invCarry = 1'b1;
      end
      OP_MCP: begin
        ctl.useAdd   = 1'b1;
        ctl.carryToR = 1'b1;
        ctl.width    = WD_WORD;
      end
      OP_MOVE: begin
        if (sizeWidth == WD_HALF || sizeWidth == WD_WORD) ctl.useNz = 1'b1;
        else                                              ctl.useAdd = 1'b1;
      end
      OP_MULU: ctl.useMulU = 1'b1;
      OP_MULS: ctl.useMulS = 1'b1;
      default: ;
    endcase
  end

  // R5
  path_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.useAdd, ctl.useNz, ctl.useMulU, ctl.useMulS}));

  // R4
  mcp_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opKind == OP_MCP) |-> (ctl.width == WD_WORD && ctl.carryToR && !ctl.invCarry));

endmodule

// File: rtl/lfe_datapath.sv
module lfe_datapath
  import lfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] resWord,
  input  logic [DATA_W-1:0] mofWord,
  input  logic              xFlagIn,
  input  logic [STAT_W-1:0] flagMask,
  input  logic [STAT_W-1:0] statusIn,
  output logic [STAT_W-1:0] statusOut
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  logic              signSrc, signDst, signRes, resZero, widthOk;
  logic [PROD_W-1:0] prodWord;
  logic [STAT_W-1:0] newFlags;
  logic [STAT_W-1:0] maskEff;
  logic [STAT_W-1:0] statusNext;

  assign prodWord = {mofWord, resWord};

  always_comb begin
    widthOk = 1'b1;
    case (ctl.width)
      WD_BYTE: begin
        signSrc = srcWord[BYTE_W-1];
        signDst = dstWord[BYTE_W-1];
        signRes = resWord[BYTE_W-1];
        resZero = (resWord[BYTE_W-1:0] == '0);
      end
      WD_HALF: begin
        signSrc = srcWord[HALF_W-1];
        signDst = dstWord[HALF_W-1];
        signRes = resWord[HALF_W-1];
        resZero = (resWord[HALF_W-1:0] == '0);
      end
      WD_WORD: begin
        signSrc = srcWord[DATA_W-1];
        signDst = dstWord[DATA_W-1];
        signRes = resWord[DATA_W-1];
        resZero = (resWord == '0);
      end
      default: begin
        signSrc = 1'b0;
        signDst = 1'b0;
        signRes = 1'b0;
        resZero = 1'b0;
        widthOk = 1'b0;
      end
    endcase
    signSrc = signSrc ^ ctl.invSrc;
  end

  always_comb begin
    logic carryLike;
    newFlags  = '0;
    carryLike = 1'b0;
    if (ctl.useAdd && widthOk) begin
      if (signRes) begin
        newFlags[BIT_N] = 1'b1;
        if (!signSrc && !signDst)     newFlags[BIT_V] = 1'b1;
        else if (signSrc && signDst)  carryLike = 1'b1;
      end else begin
        newFlags[BIT_Z] = resZero;
        newFlags[BIT_V] = signSrc & signDst;
        carryLike       = signSrc | signDst;
      end
      if (ctl.carryToR) newFlags[BIT_R] = carryLike;
      else              newFlags[BIT_C] = carryLike ^ ctl.invCarry;
    end else if (ctl.useNz && widthOk) begin
      if (signRes) newFlags[BIT_N] = 1'b1;
      else         newFlags[BIT_Z] = resZero;
    end else if (ctl.useMulU) begin
      newFlags[BIT_Z] = (prodWord == '0);
      newFlags[BIT_N] = prodWord[PROD_W-1];
      newFlags[BIT_V] = (mofWord != '0);
    end else if (ctl.useMulS) begin
      newFlags[BIT_Z] = (prodWord == '0);
      newFlags[BIT_N] = prodWord[PROD_W-1];
      newFlags[BIT_V] = resWord[DATA_W-1] ? (mofWord != '1) : (mofWord != '0);
    end
  end

  always_comb begin
    maskEff        = flagMask;
    maskEff[BIT_X] = 1'b1;
    if (xFlagIn && newFlags[BIT_Z]) maskEff[BIT_Z] = 1'b0;
    statusNext = (statusIn & ~maskEff) | (newFlags & maskEff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           statusOut <= '0;
    else if (ctl.doWrite) statusOut <= statusNext;
  end

  // R8
  x_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doWrite |=> !statusOut[BIT_X]);

  // R8
  outside_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doWrite |=> (((statusOut ^ $past(statusIn)) & ~$past(maskEff)) == '0));

  // R9
  z_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doWrite && xFlagIn && newFlags[BIT_Z]) |=> (statusOut[BIT_Z] == $past(statusIn[BIT_Z])));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.doWrite |=> $stable(statusOut));

  // R1
  nz_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doWrite |-> !(newFlags[BIT_N] && newFlags[BIT_Z]));

endmodule

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval
  import lfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalValid,
  input  logic [2:0]        opKind,
  input  logic [2:0]        opSize,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] resWord,
  input  logic [DATA_W-1:0] mofWord,
  input  logic              xFlagIn,
  input  logic [STAT_W-1:0] flagMask,
  input  logic [STAT_W-1:0] statusIn,
  output logic [STAT_W-1:0] statusOut
);

  ctrl_t ctl;
  op_e   opEnum;

  assign opEnum = op_e'(opKind);

  lfe_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .evalValid (evalValid),
    .opKind    (opEnum),
    .opSize    (opSize),
    .ctl       (ctl)
  );

  lfe_datapath #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .srcWord   (srcWord),
    .dstWord   (dstWord),
    .resWord   (resWord),
    .mofWord   (mofWord),
    .xFlagIn   (xFlagIn),
    .flagMask  (flagMask),
    .statusIn  (statusIn),
    .statusOut (statusOut)
  );

endmodule

// File: tb/lazy_flag_eval_tb.sv
module lazy_flag_eval_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;
  localparam logic [15:0] FULL_MASK = 16'h010F;

  // {op, size, src, dst, res, mof, expected flags[8:0]}
  localparam logic [142:0] VECS [NV] = '{
    {3'd0, 3'd4, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 9'h00A}, // R1 N|V
    {3'd0, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0, 9'h009}, // R1 N|C
    {3'd0, 3'd4, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h0, 9'h005}, // R2 Z|C
    {3'd0, 3'd4, 32'h80000000, 32'h80000000, 32'h00000000, 32'h0, 9'h007}, // R2 Z|V|C
    {3'd0, 3'd1, 32'h00000080, 32'h00000080, 32'h00000100, 32'h0, 9'h007}, // R2 byte mask
    {3'd0, 3'd2, 32'h00001234, 32'h00000001, 32'h00001235, 32'h0, 9'h000}, // R2 half
    {3'd1, 3'd4, 32'h00000001, 32'h00000005, 32'h00000004, 32'h0, 9'h000}, // R3 no borrow
    {3'd1, 3'd4, 32'h00000005, 32'h00000001, 32'hFFFFFFFC, 32'h0, 9'h009}, // R3 borrow
    {3'd2, 3'd1, 32'h00000001, 32'h00000001, 32'h00000000, 32'h0, 9'h004}, // R3 compare
    {3'd3, 3'd1, 32'hFFFFFFFF, 32'h00000001, 32'h00000100, 32'h0, 9'h100}, // R4 R flag
    {3'd4, 3'd4, 32'h0,        32'h0,        32'h80000000, 32'h0, 9'h008}, // R5 N
    {3'd4, 3'd2, 32'h0,        32'h0,        32'h00010000, 32'h0, 9'h004}, // R5 Z
    {3'd4, 3'd2, 32'h00008000, 32'h00008000, 32'h00008000, 32'h0, 9'h008}, // R5 N only
    {3'd4, 3'd1, 32'h00000080, 32'h00000080, 32'h00000000, 32'h0, 9'h007}, // R5 byte
    {3'd5, 3'd4, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 9'h004},        // R6 Z
    {3'd5, 3'd4, 32'h0, 32'h0, 32'h00000000, 32'h80000000, 9'h00A},        // R6 N|V
    {3'd5, 3'd4, 32'h0, 32'h0, 32'h80000000, 32'h00000000, 9'h000},        // R6 none
    {3'd6, 3'd4, 32'h0, 32'h0, 32'h80000000, 32'hFFFFFFFF, 9'h008},        // R7 N
    {3'd6, 3'd4, 32'h0, 32'h0, 32'h00000001, 32'hFFFFFFFF, 9'h00A},        // R7 N|V
    {3'd6, 3'd4, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 9'h004},        // R7 Z
    {3'd0, 3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0, 9'h000}, // R11 add
    {3'd1, 3'd0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h0, 9'h000}  // R11 sub
  };
  localparam int VREQ [NV] = '{1,1,2,2,2,2,3,3,3,4,5,5,5,5,6,6,6,7,7,7,11,11};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evalValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [2:0]  opSize = 3'd4;
  logic [31:0] srcWord = '0, dstWord = '0, resWord = '0, mofWord = '0;
  logic        xFlagIn = 1'b0;
  logic [15:0] flagMask = '0;
  logic [15:0] statusIn = '0;
  logic [15:0] statusOut;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lazy_flag_eval u_dut (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .opKind(opKind),
    .opSize(opSize), .srcWord(srcWord), .dstWord(dstWord), .resWord(resWord),
    .mofWord(mofWord), .xFlagIn(xFlagIn), .flagMask(flagMask),
    .statusIn(statusIn), .statusOut(statusOut)
  );

  task automatic check(input string req, input logic [15:0] expv);
    checks++;
    if (statusOut !== expv) begin
      errors++;
      $display("FAIL %s: statusOut=%h expected=%h", req, statusOut, expv);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [2:0] sz,
                      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
                      input logic [31:0] m, input logic x, input logic [15:0] mk,
                      input logic [15:0] st);
    evalValid = v; opKind = op; opSize = sz; srcWord = s; dstWord = d;
    resWord = r; mofWord = m; xFlagIn = x; flagMask = mk; statusIn = st;
    @(negedge clk);
    evalValid = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R12", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VECS[i][142:140], VECS[i][139:137], VECS[i][136:105],
           VECS[i][104:73], VECS[i][72:41], VECS[i][40:9], 1'b0, FULL_MASK, 16'h0000);
      check($sformatf("R%0d vec%0d", VREQ[i], i), {7'd0, VECS[i][8:0]});
    end

    // R8: outside-mask bits kept, X cleared, N not written outside mask
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h80000000, 0, 1'b0, 16'h0003, 16'hFFFF);
    check("R8", 16'hFFEC);
    // R8: masked N written
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h80000000, 0, 1'b0, 16'h000F, 16'h0010);
    check("R8", 16'h0008);

    // R9: Z kept set
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h0, 0, 1'b1, 16'h000F, 16'h0004);
    check("R9", 16'h0004);
    // R9: Z cannot be set
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h0, 0, 1'b1, 16'h000F, 16'h0000);
    check("R9", 16'h0000);
    // R9: Z may be cleared
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h1, 0, 1'b1, 16'h000F, 16'h0004);
    check("R9", 16'h0000);

    // R10: load a known value, then blocked writes
    step(1'b1, 3'd4, 3'd4, 0, 0, 32'h80000000, 0, 1'b0, 16'h000F, 16'h0A00);
    check("R12", 16'h0A08);
    step(1'b1, 3'd7, 3'd4, 0, 0, 32'h0, 0, 1'b0, 16'h00FF, 16'h5555);
    @(negedge clk);
    check("R10 live", 16'h0A08);
    step(1'b0, 3'd4, 3'd4, 0, 0, 32'h0, 0, 1'b0, 16'h00FF, 16'h5555);
    @(negedge clk);
    check("R10 novalid", 16'h0A08);

    // R12: reset clears status
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule